// File: doc/BRIEF.md
# Multi-Channel ADC Conversion Sequencer

This block is the digital controller that sits in front of a successive-approximation converter core. It walks through a programmed list of channel slots, drives the channel select, and times a sampling window followed by a fixed conversion window. It then captures the 12-bit result the core presents and stores it right-aligned in a 16-bit data register. Two groups share the core. The regular group has up to 16 slots and may scan and repeat. The injected group has up to 4 slots and takes priority: an injected trigger aborts the regular conversion in flight. After the injected slots finish, the regular group restarts that same slot.

Software programs the block through a simple write port. That port sets the group lengths, the channel for each slot, a 3-bit sampling code per channel and the mode bits. Completed conversions raise sticky flags and a level interrupt. A regular completion can also raise a one-cycle DMA request.

The controller has three states. `ST_IDLE` waits for a trigger. `ST_REG` runs a regular slot. `ST_INJ` runs an injected slot. Named transitions:
- start-regular: `ST_IDLE`→`ST_REG`.
- start-injected: `ST_IDLE`→`ST_INJ`.
- preempt: `ST_REG`→`ST_INJ`; the regular slot is aborted and remembered.
- next-slot: stays in the same state and reloads the timer.
- wrap: `ST_REG`→`ST_REG` at slot 0, in continuous mode.
- finish: →`ST_IDLE`.
- resume: `ST_INJ`→`ST_REG` at the remembered slot.
- disable: any state →`ST_IDLE` when the enable bit is clear.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `dr_out`, `jdr_out`, `eoc`, `jeoc`, `irq`, `dma_req`, `sample_on` and `convert_on` are all zero.
- R2: A regular trigger accepted in idle selects the channel of regular slot 0 on `chan_sel` from the next cycle on. `sample_on` is then high for ceil(S/2) cycles, where S is the sampling length in half-cycles.
- R3: Sampling codes 0..7 give S = 3, 15, 27, 57, 83, 111, 143, 479 half-cycles. A conversion completes (S+25)/2 cycles after the trigger edge: 14 cycles for code 0, 20 for code 1, 41 for code 3.
- R4: With scan on, regular slots 0..N are converted in order, where N is the programmed count minus one, with the next slot starting automatically.
- R5: With scan off, only slot 0 is converted.
- R6: With continuous on, the group restarts at slot 0 after its last slot. With continuous off, the block returns to idle.
- R7: An injected trigger during a regular conversion aborts it. The block then converts the injected slots and restarts the regular group at the aborted slot.
- R8: An injected completion writes the 16-bit injected register of its slot (slot k at `jdr_out[16k+15:16k]`) and sets `jeoc`. It never pulses `dma_req`.
- R9: A regular completion writes `dr_out` with the result in bits 11:0 and zeros in bits 15:12, and sets `eoc`. When DMA is enabled it also pulses `dma_req` for one cycle.
- R10: The flags are sticky. `eoc` clears on a write of bit 0 to the flag register or on `rd_dr`. `jeoc` clears on a write of bit 1 or on `rd_jdr`. A new completion wins over a clear in the same cycle.
- R11: `irq` is high while (`eoc` and the EOC interrupt enable) or (`jeoc` and the JEOC interrupt enable) holds.
- R12: Triggers are ignored while the enable bit is clear, and clearing the enable bit stops any conversion in progress.
- R13: Register map on `cfg_addr`:
  - 0x00 control: bit0 enable, bit1 scan, bit2 continuous, bit3 DMA, bit4 EOC interrupt enable, bit5 JEOC interrupt enable.
  - 0x01 lengths: bits 3:0 are the regular count minus 1; bits 9:8 are the injected count minus 1.
  - 0x02 flag clear, write one to clear.
  - 0x08+k: channel of injected slot k.
  - 0x10+k: channel of regular slot k.
  - 0x20+c: sampling code of channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| rd_dr | input | 1 | Regular data read strobe; clears `eoc` |
| rd_jdr | input | 1 | Injected data read strobe; clears `jeoc` |
| trig_reg | input | 1 | Regular group start trigger |
| trig_inj | input | 1 | Injected group start trigger |
| conv_result | input | 12 | Result from the converter core |
| chan_sel | output | 4 | Channel currently selected |
| sample_on | output | 1 | Sampling window active |
| convert_on | output | 1 | Conversion window active |
| dr_out | output | 16 | Regular data register |
| jdr_out | output | 64 | Four injected data registers, slot 0 lowest |
| eoc | output | 1 | Regular end-of-conversion flag |
| jeoc | output | 1 | Injected end-of-conversion flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request pulse |

## Verification
The bench builds the block with its default parameters: 16 channels, 16 regular slots, 4 injected slots and a 12-bit result. With these values the full 4-bit regular count and 2-bit injected count are live, and the bench converts a four-slot regular scan interrupted by a two-slot injected group. Sampling codes 0 to 3 keep each conversion at 41 cycles or fewer. That lets the bench measure exact latencies for two codes and run the preempt-and-resume ordering through the scoreboard.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REG  = 2'd1,
        ST_INJ  = 2'd2
    } seq_state_e;

    localparam int HC_W      = 10;   // half-cycle counter width
    localparam int CONV_HALF = 25;   // 12.5 conversion cycles in half-cycles

    localparam int A_CTRL     = 0;
    localparam int A_LEN      = 1;
    localparam int A_FLAG     = 2;
    localparam int A_INJ_BASE = 8;
    localparam int A_REG_BASE = 16;
    localparam int A_SMP_BASE = 32;

    // sampling length in half ADC cycles for each 3-bit code
    function automatic logic [HC_W-1:0] samp_half(input logic [2:0] code);
        case (code)
            3'd0:    samp_half = HC_W'(3);
            3'd1:    samp_half = HC_W'(15);
            3'd2:    samp_half = HC_W'(27);
            3'd3:    samp_half = HC_W'(57);
            3'd4:    samp_half = HC_W'(83);
            3'd5:    samp_half = HC_W'(111);
            3'd6:    samp_half = HC_W'(143);
            default: samp_half = HC_W'(479);
        endcase
    endfunction

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg #(
    parameter  int NUM_CH    = 16,
    parameter  int REG_SLOTS = 16,
    parameter  int INJ_SLOTS = 4,
    parameter  int ADDR_W    = 6,
    parameter  int CFG_W     = 16,
    localparam int CH_W      = $clog2(NUM_CH),
    localparam int RL_W      = $clog2(REG_SLOTS),
    localparam int IL_W      = $clog2(INJ_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  wdata,
    output logic              ctrl_on,
    output logic              ctrl_scan,
    output logic              ctrl_cont,
    output logic              ctrl_dma,
    output logic              ctrl_eoc_ie,
    output logic              ctrl_jeoc_ie,
    output logic [RL_W-1:0]   reg_last,
    output logic [IL_W-1:0]   inj_last,
    output logic [CH_W-1:0]   reg_chan [REG_SLOTS],
    output logic [CH_W-1:0]   inj_chan [INJ_SLOTS],
    output logic [2:0]        smp_code [NUM_CH],
    output logic              clr_eoc,
    output logic              clr_jeoc
);
    import adc_seq_pkg::*;

    logic [5:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reg_last <= '0;
            inj_last <= '0;
            for (int k = 0; k < REG_SLOTS; k++) reg_chan[k] <= '0;
            for (int k = 0; k < INJ_SLOTS; k++) inj_chan[k] <= '0;
            for (int c = 0; c < NUM_CH; c++)    smp_code[c] <= '0;
        end else if (we) begin
            if (addr == ADDR_W'(A_CTRL)) ctrl_q <= wdata[5:0];
            if (addr == ADDR_W'(A_LEN)) begin
                reg_last <= wdata[RL_W-1:0];
                inj_last <= wdata[8 +: IL_W];
            end
            for (int k = 0; k < REG_SLOTS; k++)
                if (addr == ADDR_W'(A_REG_BASE + k)) reg_chan[k] <= wdata[CH_W-1:0];
            for (int k = 0; k < INJ_SLOTS; k++)
                if (addr == ADDR_W'(A_INJ_BASE + k)) inj_chan[k] <= wdata[CH_W-1:0];
            for (int c = 0; c < NUM_CH; c++)
                if (addr == ADDR_W'(A_SMP_BASE + c)) smp_code[c] <= wdata[2:0];
        end
    end

    assign ctrl_on      = ctrl_q[0];
    assign ctrl_scan    = ctrl_q[1];
    assign ctrl_cont    = ctrl_q[2];
    assign ctrl_dma     = ctrl_q[3];
    assign ctrl_eoc_ie  = ctrl_q[4];
    assign ctrl_jeoc_ie = ctrl_q[5];
    assign clr_eoc      = we && (addr == ADDR_W'(A_FLAG)) && wdata[0];
    assign clr_jeoc     = we && (addr == ADDR_W'(A_FLAG)) && wdata[1];

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       run,
    input  logic [2:0] code,
    output logic       sample_on,
    output logic       done
);
    import adc_seq_pkg::*;

    logic [HC_W-1:0] hc_q;
    logic [HC_W-1:0] samp_hc;
    logic [HC_W-1:0] total_hc;

    assign samp_hc  = samp_half(code);
    assign total_hc = samp_hc + HC_W'(CONV_HALF);

    // advances two half-cycles per ADC clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hc_q <= '0;
        else if (load) hc_q <= '0;
        else if (run)  hc_q <= hc_q + HC_W'(2);
    end

    assign sample_on = run && (hc_q < samp_hc);
    assign done      = run && ((hc_q + HC_W'(2)) == total_hc);

endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
    parameter  int INJ_SLOTS = 4,
    parameter  int RES_W     = 12,
    parameter  int DR_W      = 16,
    localparam int IL_W      = $clog2(INJ_SLOTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_done,
    input  logic                      inj_done,
    input  logic [IL_W-1:0]           inj_slot,
    input  logic [RES_W-1:0]          result,
    input  logic                      rd_dr,
    input  logic                      rd_jdr,
    input  logic                      clr_eoc,
    input  logic                      clr_jeoc,
    input  logic                      dma_en,
    input  logic                      eoc_ie,
    input  logic                      jeoc_ie,
    output logic [DR_W-1:0]           dr_out,
    output logic [INJ_SLOTS*DR_W-1:0] jdr_out,
    output logic                      eoc,
    output logic                      jeoc,
    output logic                      irq,
    output logic                      dma_req
);
    logic [DR_W-1:0] aligned;
    logic [DR_W-1:0] jdr_q [INJ_SLOTS];

    assign aligned = {{(DR_W-RES_W){1'b0}}, result};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr_out  <= '0;
            eoc     <= 1'b0;
            jeoc    <= 1'b0;
            dma_req <= 1'b0;
            for (int k = 0; k < INJ_SLOTS; k++) jdr_q[k] <= '0;
        end else begin
            dma_req <= reg_done && dma_en;
            if (reg_done) begin
                dr_out <= aligned;
                eoc    <= 1'b1;
            end else if (clr_eoc || rd_dr) begin
                eoc    <= 1'b0;
            end
            if (inj_done) begin
                jdr_q[inj_slot] <= aligned;
                jeoc            <= 1'b1;
            end else if (clr_jeoc || rd_jdr) begin
                jeoc            <= 1'b0;
            end
        end
    end

    for (genvar k = 0; k < INJ_SLOTS; k++) begin : g_jdr
        assign jdr_out[k*DR_W +: DR_W] = jdr_q[k];
    end

    assign irq = (eoc && eoc_ie) || (jeoc && jeoc_ie);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter  int NUM_CH    = 16,
    parameter  int REG_SLOTS = 16,
    parameter  int INJ_SLOTS = 4,
    parameter  int RES_W     = 12,
    parameter  int DR_W      = 16,
    parameter  int ADDR_W    = 6,
    parameter  int CFG_W     = 16,
    localparam int CH_W      = $clog2(NUM_CH),
    localparam int RL_W      = $clog2(REG_SLOTS),
    localparam int IL_W      = $clog2(INJ_SLOTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [ADDR_W-1:0]         cfg_addr,
    input  logic [CFG_W-1:0]          cfg_wdata,
    input  logic                      rd_dr,
    input  logic                      rd_jdr,
    input  logic                      trig_reg,
    input  logic                      trig_inj,
    input  logic [RES_W-1:0]          conv_result,
    output logic [CH_W-1:0]           chan_sel,
    output logic                      sample_on,
    output logic                      convert_on,
    output logic [DR_W-1:0]           dr_out,
    output logic [INJ_SLOTS*DR_W-1:0] jdr_out,
    output logic                      eoc,
    output logic                      jeoc,
    output logic                      irq,
    output logic                      dma_req
);
    logic            ctrl_on, ctrl_scan, ctrl_cont, ctrl_dma, ctrl_eoc_ie, ctrl_jeoc_ie;
    logic [RL_W-1:0] reg_last;
    logic [IL_W-1:0] inj_last;
    logic [CH_W-1:0] reg_chan [REG_SLOTS];
    logic [CH_W-1:0] inj_chan [INJ_SLOTS];
    logic [2:0]      smp_code [NUM_CH];
    logic            clr_eoc, clr_jeoc;

    seq_state_e      state, state_nx;
    logic [RL_W-1:0] reg_slot, reg_slot_nx;
    logic [IL_W-1:0] inj_slot, inj_slot_nx;
    logic            resume_pend, resume_nx;
    logic            load, run, done, reg_done, inj_done;
    logic            acc_reg, acc_inj;

    adc_seq_cfg #(
        .NUM_CH(NUM_CH), .REG_SLOTS(REG_SLOTS), .INJ_SLOTS(INJ_SLOTS),
        .ADDR_W(ADDR_W), .CFG_W(CFG_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .ctrl_on(ctrl_on), .ctrl_scan(ctrl_scan), .ctrl_cont(ctrl_cont),
        .ctrl_dma(ctrl_dma), .ctrl_eoc_ie(ctrl_eoc_ie), .ctrl_jeoc_ie(ctrl_jeoc_ie),
        .reg_last(reg_last), .inj_last(inj_last), .reg_chan(reg_chan),
        .inj_chan(inj_chan), .smp_code(smp_code),
        .clr_eoc(clr_eoc), .clr_jeoc(clr_jeoc)
    );

    adc_seq_timer u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .run(run),
        .code(smp_code[chan_sel]), .sample_on(sample_on), .done(done)
    );

    adc_seq_results #(
        .INJ_SLOTS(INJ_SLOTS), .RES_W(RES_W), .DR_W(DR_W)
    ) u_res (
        .clk(clk), .rst_n(rst_n), .reg_done(reg_done), .inj_done(inj_done),
        .inj_slot(inj_slot), .result(conv_result), .rd_dr(rd_dr), .rd_jdr(rd_jdr),
        .clr_eoc(clr_eoc), .clr_jeoc(clr_jeoc), .dma_en(ctrl_dma),
        .eoc_ie(ctrl_eoc_ie), .jeoc_ie(ctrl_jeoc_ie), .dr_out(dr_out),
        .jdr_out(jdr_out), .eoc(eoc), .jeoc(jeoc), .irq(irq), .dma_req(dma_req)
    );

    assign acc_inj = ctrl_on && trig_inj && (state != ST_INJ);
    assign acc_reg = ctrl_on && trig_reg && (state == ST_IDLE);

    // next-state and transition decisions
    always_comb begin
        state_nx    = state;
        reg_slot_nx = reg_slot;
        inj_slot_nx = inj_slot;
        resume_nx   = resume_pend;
        load        = 1'b0;
        reg_done    = 1'b0;
        inj_done    = 1'b0;
        if (!ctrl_on) begin
            state_nx    = ST_IDLE;                  // disable
            resume_nx   = 1'b0;
            reg_slot_nx = '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (acc_inj) begin              // start-injected
                        state_nx    = ST_INJ;
                        inj_slot_nx = '0;
                        load        = 1'b1;
                    end else if (acc_reg) begin     // start-regular
                        state_nx    = ST_REG;
                        reg_slot_nx = '0;
                        load        = 1'b1;
                    end
                end
                ST_REG: begin
                    if (acc_inj) begin              // preempt
                        state_nx    = ST_INJ;
                        inj_slot_nx = '0;
                        resume_nx   = 1'b1;
                        load        = 1'b1;
                    end else if (done) begin
                        reg_done = 1'b1;
                        if (ctrl_scan && (reg_slot != reg_last)) begin
                            reg_slot_nx = reg_slot + 1'b1;   // next-slot
                            load        = 1'b1;
                        end else if (ctrl_cont) begin
                            reg_slot_nx = '0;                // wrap
                            load        = 1'b1;
                        end else begin
                            state_nx    = ST_IDLE;           // finish
                            reg_slot_nx = '0;
                        end
                    end
                end
                ST_INJ: begin
                    if (done) begin
                        inj_done = 1'b1;
                        if (ctrl_scan && (inj_slot != inj_last)) begin
                            inj_slot_nx = inj_slot + 1'b1;   // next-slot
                            load        = 1'b1;
                        end else if (resume_pend) begin
                            state_nx  = ST_REG;              // resume
                            resume_nx = 1'b0;
                            load      = 1'b1;
                        end else begin
                            state_nx  = ST_IDLE;             // finish
                        end
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            reg_slot    <= '0;
            inj_slot    <= '0;
            resume_pend <= 1'b0;
        end else begin
            state       <= state_nx;
            reg_slot    <= reg_slot_nx;
            inj_slot    <= inj_slot_nx;
            resume_pend <= resume_nx;
        end
    end

    // outputs toward the converter core
    always_comb begin
        run        = (state != ST_IDLE);
        chan_sel   = (state == ST_INJ) ? inj_chan[inj_slot] : reg_chan[reg_slot];
        convert_on = run && !sample_on;
    end

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
    import adc_seq_pkg::*;
#(
    parameter int INJ_SLOTS = 4,
    parameter int DR_W      = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input seq_state_e                state,
    input logic                      resume_pend,
    input logic                      ctrl_on,
    input logic                      sample_on,
    input logic                      dma_req,
    input logic                      eoc,
    input logic [DR_W-1:0]           dr_out,
    input logic [INJ_SLOTS*DR_W-1:0] jdr_out
);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sample_on);

    assert_dma_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req);

    assert_dma_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> eoc);

    assert_inj_no_dma_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(jdr_out) |-> !dma_req);

    assert_resume_in_inj_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pend |-> (state == ST_INJ));

    assert_off_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_on |=> (state == ST_IDLE));

    assert_dr_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dr_out) |-> eoc);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.INJ_SLOTS(INJ_SLOTS), .DR_W(DR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .resume_pend(resume_pend),
    .ctrl_on(ctrl_on), .sample_on(sample_on), .dma_req(dma_req), .eoc(eoc),
    .dr_out(dr_out), .jdr_out(jdr_out)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        rd_dr = 1'b0;
    logic        rd_jdr;
    logic        trig_reg = 1'b0;
    logic        trig_inj = 1'b0;
    logic [11:0] conv_result;
    logic [3:0]  chan_sel;
    logic        sample_on, convert_on, eoc, jeoc, irq, dma_req;
    logic [15:0] dr_out;
    logic [63:0] jdr_out;

    int checks = 0;
    int fails  = 0;
    int dma_cnt = 0;
    bit mon_en = 1'b0;
    bit finished = 1'b0;

    typedef struct packed { logic inj; logic [1:0] slot; logic [3:0] ch; } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    function automatic logic [11:0] model(input logic [3:0] ch);
        return {ch, ~ch, ch ^ 4'h5};
    endfunction

    assign conv_result = model(chan_sel);

    adc_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rd_dr(rd_dr), .rd_jdr(rd_jdr),
        .trig_reg(trig_reg), .trig_inj(trig_inj), .conv_result(conv_result),
        .chan_sel(chan_sel), .sample_on(sample_on), .convert_on(convert_on),
        .dr_out(dr_out), .jdr_out(jdr_out), .eoc(eoc), .jeoc(jeoc),
        .irq(irq), .dma_req(dma_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_reg();
        @(negedge clk); trig_reg = 1'b1;
        @(negedge clk); trig_reg = 1'b0;
    endtask

    task automatic pulse_inj();
        @(negedge clk); trig_inj = 1'b1;
        @(negedge clk); trig_inj = 1'b0;
    endtask

    task automatic expect_item(input bit inj, input int slot, input int ch);
        item_t it;
        it.inj = inj; it.slot = 2'(slot); it.ch = 4'(ch);
        sb_q.push_back(it);
    endtask

    task automatic wait_empty(input string req);
        int t = 0;
        while (sb_q.size() != 0 && t < 5000) begin
            @(negedge clk); t++;
        end
        chk(sb_q.size() == 0, req, sb_q.size(), 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        item_t it;
        rd_jdr <= 1'b0;
        if (rst_n && dma_req) dma_cnt++;
        if (rst_n && mon_en) begin
            if (dma_req) begin
                if (sb_q.size() == 0) chk(1'b0, "R6 unexpected regular result", dr_out, 0);
                else begin
                    it = sb_q.pop_front();
                    chk(!it.inj, "R7 order: regular where injected expected", 1, 0);
                    chk(dr_out == {4'h0, model(it.ch)}, "R4/R9 regular data", dr_out, {4'h0, model(it.ch)});
                end
            end
            if (jeoc && !rd_jdr) begin
                if (sb_q.size() == 0) chk(1'b0, "R8 unexpected injected result", jeoc, 0);
                else begin
                    it = sb_q.pop_front();
                    chk(it.inj, "R7 order: injected where regular expected", 0, 1);
                    chk(jdr_out[it.slot*16 +: 16] == {4'h0, model(it.ch)}, "R8 injected data",
                        jdr_out[it.slot*16 +: 16], {4'h0, model(it.ch)});
                    chk(!dma_req, "R8 no DMA on injected", dma_req, 0);
                end
                rd_jdr <= 1'b1;   // R10 read clears jeoc
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int cnt, sc, d0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(dr_out == 0 && jdr_out == 0, "R1 data regs", dr_out, 0);
        chk(!eoc && !jeoc && !irq && !dma_req, "R1 flags", {eoc, jeoc, irq, dma_req}, 0);
        chk(!sample_on && !convert_on, "R1 windows", {sample_on, convert_on}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 code table: ch2=1, ch14=2, ch10..13=3
        wr(32+2, 1); wr(32+14, 2);
        wr(32+10, 3); wr(32+11, 3); wr(32+12, 3); wr(32+13, 3);

        // R2/R3 timing, code 0, single slot
        wr(0, 9); wr(1, 0); wr(16, 5);
        pulse_reg();
        chk(chan_sel == 5, "R2/R13 channel select", chan_sel, 5);
        sc = sample_on; cnt = 0;
        while (!dma_req && cnt < 600) begin
            @(negedge clk); cnt++; sc += int'(sample_on);
        end
        chk(cnt == 14, "R3 latency code0", cnt, 14);
        chk(sc == 2, "R2 sampling cycles code0", sc, 2);
        chk(dr_out == {4'h0, model(5)}, "R9 right aligned", dr_out, {4'h0, model(5)});
        chk(eoc && !irq, "R11 no irq without enable", {eoc, irq}, 2);
        @(negedge clk); rd_dr = 1'b1; @(negedge clk); rd_dr = 1'b0;
        chk(!eoc, "R10 read clears eoc", eoc, 0);

        // R3 code 1
        wr(16, 2);
        pulse_reg();
        sc = sample_on; cnt = 0;
        while (!dma_req && cnt < 600) begin
            @(negedge clk); cnt++; sc += int'(sample_on);
        end
        chk(cnt == 20, "R3 latency code1", cnt, 20);
        chk(sc == 8, "R2 sampling cycles code1", sc, 8);
        wr(2, 1);
        chk(!eoc, "R10 write-one clears eoc", eoc, 0);

        // R4 scan of four slots
        mon_en = 1'b1;
        wr(0, 27); wr(1, 3); wr(16, 5); wr(17, 2); wr(18, 9); wr(19, 14);
        expect_item(0, 0, 5); expect_item(0, 1, 2); expect_item(0, 2, 9); expect_item(0, 3, 14);
        pulse_reg();
        wait_empty("R4 scan drain");
        chk(irq == 1, "R11 irq with eoc enable", irq, 1);
        wr(2, 1);
        chk(irq == 0, "R11 irq drops with flag", irq, 0);

        // R5 scan off: slot 0 only
        wr(0, 9);
        d0 = dma_cnt;
        expect_item(0, 0, 5);
        pulse_reg();
        wait_empty("R5 drain");
        repeat (60) @(negedge clk);
        chk(dma_cnt - d0 == 1, "R5 single conversion", dma_cnt - d0, 1);
        chk(!sample_on, "R6 idle after group", sample_on, 0);

        // R6 continuous, then R12 disable stops it
        wr(0, 15); wr(1, 1); wr(16, 1); wr(17, 6);
        for (int i = 0; i < 3; i++) begin
            expect_item(0, 0, 1); expect_item(0, 1, 6);
        end
        pulse_reg();
        wait_empty("R6 wrap drain");
        wr(0, 0);
        d0 = dma_cnt;
        repeat (40) @(negedge clk);
        chk(dma_cnt == d0 && !sample_on, "R12 disable stops", dma_cnt - d0, 0);

        // R7 preemption and resume
        wr(0, 11); wr(1, 3 | (1 << 8));
        wr(16, 11); wr(17, 12); wr(18, 13); wr(19, 10);
        wr(8, 7); wr(9, 3);
        expect_item(0, 0, 11); expect_item(1, 0, 7); expect_item(1, 1, 3);
        expect_item(0, 1, 12); expect_item(0, 2, 13); expect_item(0, 3, 10);
        pulse_reg();
        cnt = 0;
        while (sb_q.size() == 6 && cnt < 600) begin
            @(negedge clk); cnt++;
        end
        repeat (5) @(negedge clk);
        pulse_inj();
        wait_empty("R7 preempt drain");

        // R12 triggers ignored while disabled
        mon_en = 1'b0;
        wr(0, 8);
        d0 = dma_cnt;
        pulse_reg(); pulse_inj();
        repeat (60) @(negedge clk);
        chk(dma_cnt == d0 && !jeoc && !sample_on, "R12 trigger ignored", dma_cnt - d0, 0);

        // R8/R10/R11 injected flag
        wr(0, 33); wr(1, 0); wr(8, 4);
        d0 = dma_cnt;
        pulse_inj();
        repeat (20) @(negedge clk);
        chk(jeoc == 1, "R8 jeoc set", jeoc, 1);
        chk(jdr_out[15:0] == {4'h0, model(4)}, "R8 slot0 register", jdr_out[15:0], {4'h0, model(4)});
        chk(dma_cnt == d0, "R8 no DMA", dma_cnt - d0, 0);
        chk(irq == 1, "R11 irq from jeoc", irq, 1);
        wr(2, 2);
        chk(!jeoc && !irq, "R10 write-one clears jeoc", {jeoc, irq}, 0);

        summary();
    end
endmodule